// File: doc/BRIEF.md
# Load/Store Effective Address and Byte-Lane Decoder

This block forms the effective address of a memory access and works out which byte lanes of the addressed 64-bit doubleword that access touches. The address is a 64-bit base register plus a 16-bit signed displacement. The displacement is sign-extended before the add. The low three bits of the result select a byte offset inside the doubleword. Together with a 3-bit access size code, that offset gives an 8-bit lane-enable mask.

The address always names the lowest-order byte of the field, whatever the byte order. In little-endian mode that byte is the least-significant lane. In big-endian mode every lane index is mirrored: a field at little-endian lane i appears at lane 7 minus i.

A size and offset pair that is not allowed raises an address-error flag and forces the mask to zero. An access is never split. Results are registered: they appear one cycle after a valid request and hold while no request is presented.

Top module: `lsu_lane_unit`

## Requirements
- R1: The registered effective address equals base plus the sign-extended 16-bit displacement, modulo 2^64.
- R2: The output valid flag equals the request valid of the previous cycle. Synchronous active-low reset clears the address, the mask, the error flag and the valid flag to zero.
- R3: Size code 0 (byte) is legal at every offset. In little-endian mode it enables lane `offset` only.
- R4: Size code 1 (halfword) is legal only when offset bit 0 is 0. In little-endian mode it enables lanes offset and offset+1.
- R5: Size code 3 (word) is legal only when offset bits 1:0 are 0. In little-endian mode it enables lanes offset through offset+3.
- R6: Size code 7 (doubleword) is legal only at offset 0 and enables all eight lanes (mask 0xFF).
- R7: Size code 2 (tri-byte) is legal only at offsets 0 and 5. In little-endian mode it enables lanes offset through offset+2.
- R8: Size codes 4, 5 and 6 are always illegal.
- R9: An illegal pair sets the error flag and drives the mask to 0x00. A legal pair clears the error flag.
- R10: With the endian input at 1 (big-endian), mask bit 7-i equals the little-endian mask bit i for the same request. Legality does not depend on the endian input.
- R11: While request valid is 0, the address, mask and error outputs keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_base | input | 64 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_size | input | 3 | Access size code |
| cfg_big_endian | input | 1 | 1 selects big-endian lane mapping |
| rsp_valid | output | 1 | Registered result valid |
| rsp_addr | output | 64 | Registered effective address |
| rsp_lanes | output | 8 | Registered byte-lane enables |
| rsp_addr_err | output | 1 | Registered address-error flag |

## Verification
The hardest cases to reach from the ports are the rare legal corners: a tri-byte access that lands exactly on offset 5, and a doubleword that lands on offset 0. The offset is the low part of a 64-bit sum, so random base and displacement values seldom hit these cases in both byte orders. The stimulus therefore sweeps every size code against every offset and both endian settings. It does this by choosing the displacement so the sum's low bits hit each target. A wraparound case, with a base near all ones and a negative displacement, is also sent. Random traffic is then mixed with idle cycles in which the inputs change.

// File: rtl/lsu_lane_pkg.sv
// Shared definitions for the load/store lane unit.
// Assumes a 64-bit doubleword, that is eight byte lanes.
package lsu_lane_pkg;
    localparam int LANES = 8;
    localparam int OFS_W = $clog2(LANES);

    typedef enum logic [2:0] {
        SZ_BYTE  = 3'd0,
        SZ_HALF  = 3'd1,
        SZ_TRI   = 3'd2,
        SZ_WORD  = 3'd3,
        SZ_DWORD = 3'd7
    } acc_size_e;
endpackage

// File: rtl/lsu_ea_adder.sv
// Effective address adder: base + sign-extended displacement.
// Assumes ADDR_W > DISP_W. The sum wraps modulo 2^ADDR_W.
module lsu_ea_adder #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    // Sign-extend the displacement and add it to the base.
    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        ea       = base + disp_ext;
    end
endmodule

// File: rtl/lsu_lane_decoder.sv
// Decodes size code and byte offset into a little-endian lane mask and a
// legality flag. Assumes eight lanes. A tri-byte is legal at offset 0 and
// at the last offset where it still fits (LANES-3).
module lsu_lane_decoder
    import lsu_lane_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  logic [2:0]       size,
    output logic [LANES-1:0] le_mask,
    output logic             legal
);
    localparam logic [OFS_W-1:0] TRI_HI = OFS_W'(LANES - 3);

    logic [LANES-1:0] field;

    // Pick the field shape and alignment rule for the size code.
    always_comb begin
        field = '0;
        legal = 1'b0;
        case (acc_size_e'(size))
            SZ_BYTE: begin
                field = LANES'(1);
                legal = 1'b1;
            end
            SZ_HALF: begin
                field = LANES'(3);
                legal = (ofs[0] == 1'b0);
            end
            SZ_TRI: begin
                field = LANES'(7);
                legal = (ofs == '0) || (ofs == TRI_HI);
            end
            SZ_WORD: begin
                field = LANES'(15);
                legal = (ofs[1:0] == 2'b00);
            end
            SZ_DWORD: begin
                field = '1;
                legal = (ofs == '0);
            end
            default: begin
                field = '0;
                legal = 1'b0;
            end
        endcase
        le_mask = legal ? (field << ofs) : '0;
    end

    // R6
    always_comb begin
        dword_only_base_chk: assert (!(legal && size == 3'd7) || ofs == '0);
    end

    // R9
    always_comb begin
        legal_nonzero_chk: assert (!legal || le_mask != '0);
    end
endmodule

// File: rtl/lsu_lane_mirror.sv
// Maps a little-endian lane mask to the configured byte order.
// In big-endian mode lane i moves to lane LANES-1-i.
module lsu_lane_mirror
    import lsu_lane_pkg::*;
(
    input  logic             big_endian,
    input  logic [LANES-1:0] le_mask,
    output logic [LANES-1:0] lanes
);
    // One mux per lane selects the straight or the mirrored source bit.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lanes[i] = big_endian ? le_mask[LANES-1-i] : le_mask[i];
    end
endmodule

// File: rtl/lsu_lane_unit.sv
// Load/store address and byte-lane unit (top).
// Computes the effective address, decodes the byte lanes inside the
// addressed doubleword, flags illegal size/offset pairs, and registers
// all results one cycle after a valid request. Results hold while no
// request is presented.
// Assumes a synchronous active-low reset.
module lsu_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [2:0]        req_size,
    input  logic              cfg_big_endian,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [LANES-1:0]  rsp_lanes,
    output logic              rsp_addr_err
);
    logic [ADDR_W-1:0] ea;
    logic [LANES-1:0]  le_mask;
    logic [LANES-1:0]  lanes;
    logic              legal;
    logic              run_q;

    lsu_ea_adder #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_adder (
        .base (req_base),
        .disp (req_disp),
        .ea   (ea)
    );

    lsu_lane_decoder u_dec (
        .ofs     (ea[OFS_W-1:0]),
        .size    (req_size),
        .le_mask (le_mask),
        .legal   (legal)
    );

    lsu_lane_mirror u_mirror (
        .big_endian (cfg_big_endian),
        .le_mask    (le_mask),
        .lanes      (lanes)
    );

    // Register results on a valid request and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_addr     <= '0;
            rsp_lanes    <= '0;
            rsp_addr_err <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_addr     <= ea;
                rsp_lanes    <= lanes;
                rsp_addr_err <= !legal;
            end
        end
    end

    // Mark that at least one clock has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // R9
    err_zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_addr_err |-> rsp_lanes == '0);

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n || !run_q)
        rsp_valid == $past(req_valid));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !run_q)
        !$past(req_valid) |-> ($stable(rsp_addr) && $stable(rsp_lanes) && $stable(rsp_addr_err)));

    // R1
    ea_capture_chk: assert property (@(posedge clk) disable iff (!rst_n || !run_q)
        $past(req_valid) |-> rsp_addr == $past(ea));
endmodule

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [63:0] req_base;
    logic [15:0] req_disp;
    logic [2:0]  req_size;
    logic        cfg_big_endian;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic [7:0]  rsp_lanes;
    logic        rsp_addr_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lsu_lane_unit u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_base       (req_base),
        .req_disp       (req_disp),
        .req_size       (req_size),
        .cfg_big_endian (cfg_big_endian),
        .rsp_valid      (rsp_valid),
        .rsp_addr       (rsp_addr),
        .rsp_lanes      (rsp_lanes),
        .rsp_addr_err   (rsp_addr_err)
    );

    function automatic bit exp_legal(input logic [2:0] sz, input logic [2:0] o);
        case (sz)
            3'd0:    return 1'b1;
            3'd1:    return o[0] == 1'b0;
            3'd2:    return (o == 3'd0) || (o == 3'd5);
            3'd3:    return o[1:0] == 2'b00;
            3'd7:    return o == 3'd0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] exp_lanes(input logic [2:0] sz, input logic [2:0] o, input logic be);
        int n;
        logic [7:0] m;
        n = (sz == 3'd0) ? 1 : (sz == 3'd1) ? 2 : (sz == 3'd2) ? 3 : (sz == 3'd3) ? 4 : 8;
        m = '0;
        if (exp_legal(sz, o))
            for (int k = 0; k < n; k++) begin
                if (be) m[7 - (int'(o) + k)] = 1'b1;
                else    m[int'(o) + k]       = 1'b1;
            end
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge and check it at the next falling edge.
    task automatic apply(input logic [63:0] b, input logic [15:0] d, input logic [2:0] sz, input logic be);
        logic [63:0] ea;
        logic [7:0]  m;
        bit          lg;
        req_valid = 1'b1; req_base = b; req_disp = d; req_size = sz; cfg_big_endian = be;
        ea = b + {{48{d[15]}}, d};
        lg = exp_legal(sz, ea[2:0]);
        m  = exp_lanes(sz, ea[2:0], be);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R2 valid", 64'(rsp_valid), 64'd1);
        check(rsp_addr == ea, "R1 addr", rsp_addr, ea);
        check(rsp_addr_err == !lg, "R9 err (R3 R4 R5 R6 R7 R8)", 64'(rsp_addr_err), 64'(!lg));
        check(rsp_lanes == m, be ? "R10 lanes" : "R3 R4 R5 R6 R7 lanes", 64'(rsp_lanes), 64'(m));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] hold_a;
        logic [7:0]  hold_l;
        logic        hold_e;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; req_valid = 1'b0; req_base = '1; req_disp = '1; req_size = 3'd7; cfg_big_endian = 1'b0;
        repeat (3) @(negedge clk);
        check(rsp_valid == 0 && rsp_addr == 0 && rsp_lanes == 0 && rsp_addr_err == 0,
              "R2 reset", {rsp_addr[54:0], rsp_lanes, rsp_addr_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2 idle", 64'(rsp_valid), 64'd0);

        // Full sweep: all size codes, all offsets, both byte orders (R3..R8, R10).
        for (int be = 0; be < 2; be++)
            for (int sz = 0; sz < 8; sz++)
                for (int o = 0; o < 8; o++)
                    apply(64'h0000_1234_5678_9a00, 16'(o), 3'(sz), 1'(be));

        // R1 wraparound and negative displacement corners.
        apply(64'hffff_ffff_ffff_fffc, 16'h0004, 3'd7, 1'b0);
        apply(64'h0000_0000_0000_0003, 16'h8000, 3'd0, 1'b1);
        apply(64'h7fff_ffff_ffff_ffff, 16'h0001, 3'd3, 1'b0);
        apply(64'h0, 16'hfffb, 3'd2, 1'b1);

        // R11: inputs change with valid low; outputs must hold.
        hold_a = rsp_addr; hold_l = rsp_lanes; hold_e = rsp_addr_err;
        req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            req_base = {$urandom, $urandom}; req_disp = 16'($urandom);
            req_size = 3'($urandom); cfg_big_endian = 1'($urandom);
            @(negedge clk);
            check(rsp_valid == 1'b0, "R2 idle valid", 64'(rsp_valid), 64'd0);
            check(rsp_addr == hold_a && rsp_lanes == hold_l && rsp_addr_err == hold_e,
                  "R11 hold", {rsp_addr[54:0], rsp_lanes, rsp_addr_err}, {hold_a[54:0], hold_l, hold_e});
        end

        // Random traffic mixed with idle cycles.
        for (int i = 0; i < 400; i++) begin
            apply({$urandom, $urandom}, 16'($urandom), 3'($urandom), 1'($urandom));
            if ($urandom_range(0, 3) == 0) begin
                req_valid = 1'b0;
                @(negedge clk);
                check(rsp_valid == 1'b0, "R2 gap", 64'(rsp_valid), 64'd0);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule